// File: doc/BRIEF.md
# Host Register and Clock Controller

This block sits between a byte-wide host port, shaped like a bidirectional parallel port, and a decimating modulator filter. The host writes a clock-select register and a 16-bit decimation ratio split over two byte registers, and reads each of them back. The block turns the clock code into a modulator clock by dividing the master clock, and it hands the filter a decimation ratio that is already clamped to the legal range.

The filter delivers 40-bit result words with a one-cycle load strobe. The host pulls each word out as five bytes. Reading the lowest byte freezes the other four, so a word that arrives during the read cannot tear the value the host assembles. A ready flag is raised when a word lands and dropped when the host reads the top byte. The flag can be seen as a port and as the top bit of the configuration readback.

Top module: `hrc_top`

## Requirements
- R1: After a synchronous active-low reset, the configuration and both decimation registers are zero, mod_clk is low, res_ready is low and dec_ratio is 1.
- R2: A write strobe stores host_wdata at address 0 (configuration, bits 6:0 kept), 1 (ratio low byte) or 2 (ratio high byte). host_rdata shows the addressed register combinationally; address 0 reads as {res_ready, config[6:0]}.
- R3: With code = config[2:0], mod_clk has a period of 2^(code+2) master clock cycles.
- R4: mod_clk is high for exactly half of each period.
- R5: dec_ratio is {high byte, low byte}, forced to 1 when that value is 0 and to 8192 when it is above 8192.
- R6: A res_load pulse captures res_word. Address 3 reads byte 0 (bits 7:0) of the captured word directly, and addresses 4 to 7 read bytes 1 to 4, least significant first.
- R7: A read strobe at address 3 copies the captured word into a snapshot, and addresses 4 to 7 return snapshot bytes. A later res_load does not change them until the next read at address 3.
- R8: res_ready is set in the cycle after res_load and cleared after a read strobe at address 7. When both happen in the same cycle, set wins.
- R9: Writes to addresses 3 to 7 change no register and no result byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 3 | Register address |
| host_wr | input | 1 | Write strobe, one cycle |
| host_rd | input | 1 | Read strobe, one cycle, triggers snapshot and ready clear |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr |
| res_load | input | 1 | Filter result valid pulse |
| res_word | input | 40 | Filter result word |
| dec_ratio | output | 14 | Clamped decimation ratio to the filter |
| mod_clk | output | 1 | Divided modulator clock |
| res_ready | output | 1 | New result waiting |

## Verification
The bench drives ratio values of zero, exactly 8192, and 8193 and above. A clamp that is off by one would pass 8193, or would pass 0 through unchanged. It measures the period and high time of mod_clk for all eight codes, which exposes a divider that counts one extra cycle or has an unequal duty cycle. It loads a new word between the byte-0 read and the byte-1 read, so a design without the snapshot would return bytes of the new word. It also raises res_load in the same cycle as the top-byte read, so a clear that wins over set would lose that result.

// File: rtl/hrc_pkg.sv
// Shared address map and sizes for the host register block.
// Assumes a 3-bit host address and a 40-bit result word.
package hrc_pkg;
    localparam int ADDR_W    = 3;
    localparam int RES_BYTES = 5;
    localparam int RES_W     = RES_BYTES * 8;

    typedef enum logic [ADDR_W-1:0] {
        A_CFG = 3'd0,
        A_DLO = 3'd1,
        A_DHI = 3'd2,
        A_RB0 = 3'd3,
        A_RB1 = 3'd4,
        A_RB2 = 3'd5,
        A_RB3 = 3'd6,
        A_RB4 = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/hrc_clkdiv.sv
// Divides the master clock by 2^(code+2) with 50% duty.
// Assumes code can change at any time; the counter bound uses >= so
// a shorter divide takes effect within one half period.
module hrc_clkdiv #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    output logic              mod_clk
);
    localparam int MAX_HALF = 1 << (1 << CODE_W);
    localparam int CNT_W    = $clog2(MAX_HALF);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   half;
    logic             at_end;

    // half period length in master cycles for the current code
    always_comb begin
        half   = {{CNT_W{1'b0}}, 1'b1} << (32'(code) + 1);
        at_end = ({1'b0, cnt_q} + 1'b1) >= half;
    end

    // counter and output toggle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            mod_clk <= 1'b0;
        end else if (at_end) begin
            cnt_q   <= '0;
            mod_clk <= ~mod_clk;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    p_hold_mid_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(code) && !at_end) |=> $stable(mod_clk));
    p_restart_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        at_end |=> (cnt_q == '0) && (mod_clk != $past(mod_clk)));
endmodule

// File: rtl/hrc_regs.sv
// Configuration and decimation byte registers, with ratio clamping.
// Assumes one write strobe per cycle; result addresses are not writable.
module hrc_regs
    import hrc_pkg::*;
#(
    parameter int DEC_MAX = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [6:0]        cfg_q,
    output logic [7:0]        dlo_q,
    output logic [7:0]        dhi_q,
    output logic [$clog2(DEC_MAX+1)-1:0] ratio
);
    localparam int RATIO_W = $clog2(DEC_MAX + 1);

    logic [15:0] raw;

    // byte register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            dlo_q <= '0;
            dhi_q <= '0;
        end else if (wr) begin
            case (addr)
                A_CFG:   cfg_q <= wdata[6:0];
                A_DLO:   dlo_q <= wdata;
                A_DHI:   dhi_q <= wdata;
                default: ;
            endcase
        end
    end

    // combine bytes and clamp into the legal ratio range
    always_comb begin
        raw = {dhi_q, dlo_q};
        if (raw == 16'd0)
            ratio = RATIO_W'(1);
        else if (raw > 16'(DEC_MAX))
            ratio = RATIO_W'(DEC_MAX);
        else
            ratio = raw[RATIO_W-1:0];
    end

    p_ratio_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio >= RATIO_W'(1)) && (32'(ratio) <= DEC_MAX));
    p_result_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr >= A_RB0) |=> ($stable(cfg_q) && $stable(dlo_q) && $stable(dhi_q)));
endmodule

// File: rtl/hrc_result.sv
// Holds the filter result, a read snapshot and the ready flag.
// Assumes the host reads address 3 first and address 7 last.
module hrc_result
    import hrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [RES_W-1:0]  word,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        byte_o,
    output logic              ready
);
    logic [RES_W-1:0] res_q;
    logic [RES_W-1:0] snap_q;
    logic             rd_first;
    logic             rd_last;

    // decode the read strobes with side effects
    always_comb begin
        rd_first = rd && (addr == A_RB0);
        rd_last  = rd && (addr == A_RB4);
    end

    // capture the word, take the snapshot and track readiness
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            snap_q <= '0;
            ready  <= 1'b0;
        end else begin
            if (load)     res_q  <= word;
            if (rd_first) snap_q <= res_q;
            if (load)          ready <= 1'b1;
            else if (rd_last)  ready <= 1'b0;
        end
    end

    // byte 0 from the live word, higher bytes from the snapshot
    always_comb begin
        byte_o = '0;
        for (int b = 0; b < RES_BYTES; b++) begin
            if (32'(addr) == 32'(A_RB0) + b)
                byte_o = (b == 0) ? res_q[7:0] : snap_q[b*8 +: 8];
        end
    end

    p_load_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (res_q == $past(word)));
    p_snap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_first |=> $stable(snap_q));
    p_ready_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ready);
    p_ready_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_last && !load) |=> !ready);
endmodule

// File: rtl/hrc_top.sv
// Host register and clock controller top: register file, clock divider,
// result readout and the read-data multiplexer.
// Assumes a single master clock domain and one-cycle host strobes.
module hrc_top
    import hrc_pkg::*;
#(
    parameter int CODE_W  = 3,
    parameter int DEC_MAX = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              res_load,
    input  logic [39:0]       res_word,
    output logic [13:0]       dec_ratio,
    output logic              mod_clk,
    output logic              res_ready
);
    logic [6:0] cfg_q;
    logic [7:0] dlo_q;
    logic [7:0] dhi_q;
    logic [7:0] res_byte;

    hrc_regs #(.DEC_MAX(DEC_MAX)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(host_wr), .addr(host_addr),
        .wdata(host_wdata), .cfg_q(cfg_q), .dlo_q(dlo_q), .dhi_q(dhi_q),
        .ratio(dec_ratio)
    );

    hrc_clkdiv #(.CODE_W(CODE_W)) u_div (
        .clk(clk), .rst_n(rst_n), .code(cfg_q[CODE_W-1:0]), .mod_clk(mod_clk)
    );

    hrc_result u_res (
        .clk(clk), .rst_n(rst_n), .load(res_load), .word(res_word),
        .rd(host_rd), .addr(host_addr), .byte_o(res_byte), .ready(res_ready)
    );

    // read-data multiplexer
    always_comb begin
        case (host_addr)
            A_CFG:   host_rdata = {res_ready, cfg_q};
            A_DLO:   host_rdata = dlo_q;
            A_DHI:   host_rdata = dhi_q;
            default: host_rdata = res_byte;
        endcase
    end
endmodule

// File: tb/tb_hrc_top.sv
module tb_hrc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        res_load = 1'b0;
    logic [39:0] res_word = '0;
    logic [13:0] dec_ratio;
    logic        mod_clk;
    logic        res_ready;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    hrc_top dut (.*);

    // {hi, lo, expected ratio}
    localparam logic [29:0] VEC [8] = '{
        {8'h00, 8'h00, 14'd1},    {8'h00, 8'h01, 14'd1},
        {8'h00, 8'h40, 14'd64},   {8'h01, 8'h00, 14'd256},
        {8'h1F, 8'hFF, 14'd8191}, {8'h20, 8'h00, 14'd8192},
        {8'h20, 8'h01, 14'd8192}, {8'hFF, 8'hFF, 14'd8192}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    // combinational peek, no strobe
    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    // strobed read: data sampled before the edge that acts on the strobe
    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1;
        d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic load_word(input logic [39:0] w);
        @(negedge clk);
        res_word = w; res_load = 1'b1;
        @(negedge clk);
        res_load = 1'b0;
    endtask

    task automatic wait_rise();
        logic prev;
        prev = mod_clk;
        @(negedge clk);
        while (!(mod_clk && !prev)) begin
            prev = mod_clk;
            @(negedge clk);
        end
    endtask

    task automatic measure(output int per, output int hi);
        logic prev;
        wait_rise();
        per = 0; hi = 0;
        do begin
            if (mod_clk) hi++;
            per++;
            prev = mod_clk;
            @(negedge clk);
        end while (!(mod_clk && !prev));
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int per, hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(3'd0, d);
        chk(d == 8'h00, "R1 config after reset", d, 0);
        chk(dec_ratio == 14'd1, "R1 ratio after reset", dec_ratio, 1);
        chk(mod_clk == 1'b0 || mod_clk == 1'b1, "R1 mod_clk known", mod_clk, 0);
        chk(res_ready == 1'b0, "R1 ready after reset", res_ready, 0);

        // R2 / R5 vector table
        foreach (VEC[i]) begin
            wr_reg(3'd1, VEC[i][21:14]);
            wr_reg(3'd2, VEC[i][29:22]);
            peek(3'd1, d);
            chk(d == VEC[i][21:14], "R2 low byte readback", d, VEC[i][21:14]);
            peek(3'd2, d);
            chk(d == VEC[i][29:22], "R2 high byte readback", d, VEC[i][29:22]);
            chk(dec_ratio == VEC[i][13:0], "R5 clamped ratio", dec_ratio, VEC[i][13:0]);
        end

        // R2 config readback drops written bit 7
        wr_reg(3'd0, 8'hD5);
        peek(3'd0, d);
        chk(d == 8'h55, "R2 config readback", d, 8'h55);

        // R3 / R4 divider, all codes
        for (int c = 0; c < 8; c++) begin
            wr_reg(3'd0, 8'(c));
            measure(per, hi);
            chk(per == (1 << (c + 2)), "R3 mod_clk period", per, 1 << (c + 2));
            chk(hi == (1 << (c + 1)), "R4 mod_clk high time", hi, 1 << (c + 1));
        end
        wr_reg(3'd0, 8'h00);

        // R6 / R8 load and ready
        load_word(40'h11_2233_4455);
        chk(res_ready == 1'b1, "R8 ready after load", res_ready, 1);
        peek(3'd0, d);
        chk(d == 8'h80, "R8 ready in config bit 7", d, 8'h80);
        rd_reg(3'd3, d);
        chk(d == 8'h55, "R6 byte 0", d, 8'h55);

        // R7 new word arrives mid-read
        load_word(40'hAA_BBCC_DDEE);
        rd_reg(3'd4, d); chk(d == 8'h44, "R7 byte 1 from snapshot", d, 8'h44);
        rd_reg(3'd5, d); chk(d == 8'h33, "R7 byte 2 from snapshot", d, 8'h33);
        rd_reg(3'd6, d); chk(d == 8'h22, "R7 byte 3 from snapshot", d, 8'h22);
        rd_reg(3'd7, d); chk(d == 8'h11, "R7 byte 4 from snapshot", d, 8'h11);
        chk(res_ready == 1'b0, "R8 ready cleared by top byte", res_ready, 0);

        // R6 next word read in full
        rd_reg(3'd3, d); chk(d == 8'hEE, "R6 new byte 0", d, 8'hEE);
        rd_reg(3'd4, d); chk(d == 8'hDD, "R6 new byte 1", d, 8'hDD);
        rd_reg(3'd7, d); chk(d == 8'hAA, "R6 new byte 4", d, 8'hAA);

        // R8 set wins over clear
        @(negedge clk);
        res_word = 40'h01_0203_0405; res_load = 1'b1;
        host_addr = 3'd7; host_rd = 1'b1;
        @(negedge clk);
        res_load = 1'b0; host_rd = 1'b0;
        chk(res_ready == 1'b1, "R8 set wins", res_ready, 1);

        // R9 writes to result addresses ignored
        wr_reg(3'd1, 8'h34);
        wr_reg(3'd2, 8'h12);
        wr_reg(3'd5, 8'hFF);
        wr_reg(3'd3, 8'hFF);
        wr_reg(3'd7, 8'hFF);
        peek(3'd0, d); chk(d == 8'h80, "R9 config untouched", d, 8'h80);
        peek(3'd1, d); chk(d == 8'h34, "R9 low byte untouched", d, 8'h34);
        peek(3'd2, d); chk(d == 8'h12, "R9 high byte untouched", d, 8'h12);
        peek(3'd3, d); chk(d == 8'h05, "R9 byte 0 untouched", d, 8'h05);
        peek(3'd4, d); chk(d == 8'hDD, "R9 snapshot untouched", d, 8'hDD);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule